// File: doc/BRIEF.md
# ALU Status and Bank Register

This block is the 8-bit status register of a small 8-bit microcontroller core. When the datapath raises an update enable, the block takes the current ALU operands and operation and records the arithmetic flags: zero, digit carry and carry. For subtraction, carry and digit carry are recorded as inverted borrows. The same register also holds the bank-select bits for data memory. From those bits it forms two 9-bit data-memory addresses: one from a 7-bit direct operand and one from an 8-bit indirect pointer.

Two status bits, time-out and power-down, report sleep and watchdog history. They change only on three event strobes: sleep, watchdog-clear and watchdog time-out. The CPU write port cannot alter them. The ALU result path, the watchdog counter and the memory array lie outside the block. Every register change takes effect on the rising clock edge after its cause. All outputs come straight from the register.

Top module: `cpu_status_reg`

## Requirements
- R1: The status value is laid out as bit 7 indirect-bank bit, bit 6 bank bit 1, bit 5 bank bit 0, bit 4 time-out (TO), bit 3 power-down (PD), bit 2 zero (Z), bit 1 digit carry (DC) and bit 0 carry (C). Reset clears bits 7:5 and sets TO and PD to 1. Z, DC and C are not initialised by reset. Every update appears on the outputs after the next rising clock edge.
- R2: When upd_z is 1, Z becomes 1 if the 8-bit result of the selected operation is zero, and 0 otherwise. alu_op codes are 0 add (a+b), 1 subtract (a-b), 2 AND, 3 OR and 4 XOR.
- R3: On add with upd_cdc at 1, C becomes the carry out of bit 7 and DC becomes the carry out of bit 3.
- R4: On subtract with upd_cdc at 1, C becomes 1 when a >= b (no borrow) and DC becomes 1 when a[3:0] >= b[3:0].
- R5: Z holds its value while upd_z and wr_en are both 0. C and DC hold while wr_en is 0 and there is no add or subtract with upd_cdc at 1; a logic operation with upd_cdc at 1 leaves them unchanged.
- R6: dir_addr is {bit 6, bit 5, dir_off[6:0]}, so bank 00 covers 000h-07Fh, 01 covers 080h-0FFh, 10 covers 100h-17Fh and 11 covers 180h-1FFh.
- R7: ind_addr is {bit 7, ind_ptr[7:0]}.
- R8: When wr_en is 1, bits 7, 6, 5, 2, 1 and 0 take the matching bits of wr_data. TO and PD are unaffected by any write.
- R9: When a write and a flag update land in the same cycle, the flag update decides each flag it covers. The write still sets the bank bits.
- R10: A watchdog time-out clears TO and takes priority over the other events. Otherwise a sleep or a watchdog-clear sets TO.
- R11: A sleep clears PD and takes priority over a watchdog-clear. A watchdog-clear alone sets PD. A time-out alone leaves PD unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_a | input | DATA_W | First ALU operand |
| alu_b | input | DATA_W | Second ALU operand (subtrahend) |
| alu_op | input | 3 | Operation code |
| upd_z | input | 1 | Record zero flag |
| upd_cdc | input | 1 | Record carry and digit carry (arithmetic ops only) |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write value |
| ev_sleep | input | 1 | Sleep executed |
| ev_wdt_clr | input | 1 | Watchdog-clear executed |
| ev_wdt_timeout | input | 1 | Watchdog time-out |
| dir_off | input | OFF_W | Direct operand offset |
| ind_ptr | input | OFF_W+1 | Indirect pointer |
| status_q | output | 8 | Register value |
| z_o | output | 1 | Zero flag |
| dc_o | output | 1 | Digit carry flag |
| c_o | output | 1 | Carry flag |
| dir_addr | output | OFF_W+2 | Direct data address |
| ind_addr | output | OFF_W+2 | Indirect data address |

## Verification
The bench uses the default DATA_W of 8 and OFF_W of 7, which keeps the operand and address spaces small. That lets it walk every value of alu_a against a strided set of alu_b values for add and subtract, so both the carry and the nibble-carry boundaries are crossed. It also covers every offset, pointer and bank code for address formation, every write value, and all eight combinations of the three event strobes from each of the four TO/PD starting states.

// File: rtl/status_pkg.sv
package status_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } alu_op_e;

  localparam int STAT_W  = 8;
  localparam int B_IBANK = 7;
  localparam int B_BANK1 = 6;
  localparam int B_BANK0 = 5;
  localparam int B_TO    = 4;
  localparam int B_PD    = 3;
  localparam int B_Z     = 2;
  localparam int B_DC    = 1;
  localparam int B_C     = 0;
  localparam logic [STAT_W-1:0] WR_MASK = 8'b1110_0111;
endpackage

// File: rtl/stat_flag_calc.sv
module stat_flag_calc
  import status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [2:0]        op,
  output logic              res_zero,
  output logic              c_out,
  output logic              dc_out,
  output logic              is_arith
);
  localparam int NIB_W = DATA_W / 2;

  logic [DATA_W:0]     full_sum;
  logic [NIB_W:0]      low_sum;
  logic [DATA_W-1:0]   b_eff;
  logic [DATA_W-1:0]   result;
  logic                sub_sel;

  always_comb begin
    sub_sel  = (op == OP_SUB);
    is_arith = (op == OP_ADD) || sub_sel;
    // subtraction as a + ~b + 1: carry out doubles as "no borrow"
    b_eff    = sub_sel ? ~b : b;
    full_sum = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_sel};
    low_sum  = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
             + {{NIB_W{1'b0}}, sub_sel};
    unique case (op)
      OP_AND:  result = a & b;
      OP_OR:   result = a | b;
      OP_XOR:  result = a ^ b;
      default: result = full_sum[DATA_W-1:0];
    endcase
    res_zero = (result == '0);
    c_out    = full_sum[DATA_W];
    dc_out   = low_sum[NIB_W];
  end
endmodule

// File: rtl/stat_addr_form.sv
module stat_addr_form #(
  parameter int OFF_W = 7
) (
  input  logic [1:0]       bank,
  input  logic             ibank,
  input  logic [OFF_W-1:0] off,
  input  logic [OFF_W:0]   ptr,
  output logic [OFF_W+1:0] dir_addr,
  output logic [OFF_W+1:0] ind_addr
);
  always_comb begin
    dir_addr = {bank, off};
    ind_addr = {ibank, ptr};
  end
endmodule

// File: rtl/stat_pwr_bits.sv
module stat_pwr_bits (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] hold_in,
  input  logic       ev_sleep,
  input  logic       ev_clr,
  input  logic       ev_tmo,
  output logic       to_q,
  output logic       pd_q
);
  logic to_d, pd_d, pwr_en;

  always_comb begin
    pwr_en = ev_sleep | ev_clr | ev_tmo;
    to_d   = hold_in[1];
    pd_d   = hold_in[0];
    if (ev_tmo)                to_d = 1'b0;
    else if (ev_sleep | ev_clr) to_d = 1'b1;
    if (ev_sleep)              pd_d = 1'b0;
    else if (ev_clr)           pd_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q <= 1'b1;
      pd_q <= 1'b1;
    end else if (pwr_en) begin
      to_q <= to_d;
      pd_q <= pd_d;
    end
  end

  a_r10_timeout_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tmo |=> !to_q);
  a_r10_sleep_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sleep || ev_clr) && !ev_tmo |=> to_q);
  a_r11_sleep_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sleep |=> !pd_q);
  a_r11_tmo_keeps_pd: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tmo && !ev_sleep && !ev_clr |=> $stable(pd_q));
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
  import status_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] alu_a,
  input  logic [DATA_W-1:0] alu_b,
  input  logic [2:0]        alu_op,
  input  logic              upd_z,
  input  logic              upd_cdc,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              ev_sleep,
  input  logic              ev_wdt_clr,
  input  logic              ev_wdt_timeout,
  input  logic [OFF_W-1:0]  dir_off,
  input  logic [OFF_W:0]    ind_ptr,
  output logic [7:0]        status_q,
  output logic              z_o,
  output logic              dc_o,
  output logic              c_o,
  output logic [OFF_W+1:0]  dir_addr,
  output logic [OFF_W+1:0]  ind_addr
);
  localparam int ADDR_W = OFF_W + 2;

  logic [2:0]        bank_q, bank_d;
  logic              z_q, dc_q, c_q;
  logic              z_d, dc_d, c_d;
  logic              flag_en;
  logic              to_q, pd_q;
  logic              f_zero, f_c, f_dc, f_arith, cdc_load;
  logic [STAT_W-1:0] wr_merge, pick;
  logic [ADDR_W-1:0] da, ia;

  stat_flag_calc #(.DATA_W(DATA_W)) u_flags (
    .a(alu_a), .b(alu_b), .op(alu_op),
    .res_zero(f_zero), .c_out(f_c), .dc_out(f_dc), .is_arith(f_arith)
  );

  stat_pwr_bits u_pwr (
    .clk(clk), .rst_n(rst_n), .hold_in(pick[B_TO:B_PD]),
    .ev_sleep(ev_sleep), .ev_clr(ev_wdt_clr), .ev_tmo(ev_wdt_timeout),
    .to_q(to_q), .pd_q(pd_q)
  );

  stat_addr_form #(.OFF_W(OFF_W)) u_addr (
    .bank(bank_q[1:0]), .ibank(bank_q[2]), .off(dir_off), .ptr(ind_ptr),
    .dir_addr(da), .ind_addr(ia)
  );

  // next-state: write merge first, flag updates override it
  always_comb begin
    wr_merge = (status_q & ~WR_MASK) | (wr_data & WR_MASK);
    pick     = wr_en ? wr_merge : status_q;
    cdc_load = upd_cdc & f_arith;
    bank_d   = pick[B_IBANK:B_BANK0];
    z_d      = upd_z    ? f_zero : pick[B_Z];
    c_d      = cdc_load ? f_c    : pick[B_C];
    dc_d     = cdc_load ? f_dc   : pick[B_DC];
    flag_en  = wr_en | upd_z | cdc_load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bank_q <= '0;
    else if (wr_en) bank_q <= bank_d;
  end

  // arithmetic flags carry no reset
  always_ff @(posedge clk) begin
    if (flag_en) begin
      z_q  <= z_d;
      c_q  <= c_d;
      dc_q <= dc_d;
    end
  end

  always_comb begin
    status_q = {bank_q, to_q, pd_q, z_q, dc_q, c_q};
    z_o      = z_q;
    dc_o     = dc_q;
    c_o      = c_q;
    dir_addr = da;
    ind_addr = ia;
  end

  a_r2_equal_sub_zero: assert property (@(posedge clk) disable iff (!rst_n)
    upd_z && alu_op == OP_SUB && alu_a == alu_b |=> z_o);
  a_r4_sub_zero_noborrow: assert property (@(posedge clk) disable iff (!rst_n)
    upd_cdc && alu_op == OP_SUB && alu_b == '0 |=> c_o && dc_o);
  a_r5_z_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_z && !wr_en |=> $stable(z_o));
  a_r8_write_keeps_pwr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !ev_sleep && !ev_wdt_clr && !ev_wdt_timeout
    |=> $stable(status_q[B_TO:B_PD]));
  a_r9_update_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_data[B_Z] && upd_z && alu_op == OP_XOR && alu_a == alu_b
    |=> z_o);
endmodule

// File: tb/tb_cpu_status_reg.sv
`timescale 1ns/1ps
module tb_cpu_status_reg;
  logic       clk, rst_n;
  logic [7:0] alu_a, alu_b, wr_data, status_q;
  logic [2:0] alu_op;
  logic       upd_z, upd_cdc, wr_en, ev_sleep, ev_wdt_clr, ev_wdt_timeout;
  logic [6:0] dir_off;
  logic [7:0] ind_ptr;
  logic       z_o, dc_o, c_o;
  logic [8:0] dir_addr, ind_addr;
  int n_chk = 0, n_bad = 0;

  cpu_status_reg dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    upd_z = 0; upd_cdc = 0; wr_en = 0; ev_sleep = 0; ev_wdt_clr = 0;
    ev_wdt_timeout = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic write_reg(logic [7:0] v);
    idle(); wr_en = 1; wr_data = v; tick(); idle();
  endtask

  task automatic events(logic s, logic c, logic t);
    idle(); ev_sleep = s; ev_wdt_clr = c; ev_wdt_timeout = t; tick(); idle();
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [8:0] s9;
    logic [7:0] exp8;
    logic       eto, epd;
    idle(); alu_a = 0; alu_b = 0; alu_op = 0; wr_data = 0; dir_off = 0; ind_ptr = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #5;
    // R1 reset state
    check("R1 reset bank/TO/PD", {8'h0, status_q[7:3], 3'b0}, 16'h0018);

    // R8 write sweep, TO/PD untouched
    for (int v = 0; v < 256; v++) begin
      write_reg(v[7:0]);
      exp8 = (v[7:0] & 8'hE7) | 8'h18;
      check("R8 write", {8'h0, status_q}, {8'h0, exp8});
    end

    // R6 R7 address formation over every bank code
    for (int bk = 0; bk < 8; bk++) begin
      write_reg({bk[2:0], 5'b0});
      for (int o = 0; o < 256; o++) begin
        dir_off = o[6:0]; ind_ptr = o[7:0]; #1;
        check("R6 direct addr", {7'h0, dir_addr}, {7'h0, bk[1:0], o[6:0]});
        check("R7 indirect addr", {7'h0, ind_addr}, {7'h0, bk[2], o[7:0]});
      end
    end

    // R2 R3 add sweep
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 3) begin
        idle(); alu_op = 3'd0; alu_a = a[7:0]; alu_b = b[7:0];
        upd_z = 1; upd_cdc = 1; tick();
        s9 = a[8:0] + b[8:0];
        check("R3 add C", {15'h0, c_o}, {15'h0, s9[8]});
        check("R3 add DC", {15'h0, dc_o}, {15'h0, (a % 16 + b % 16) > 15});
        check("R2 add Z", {15'h0, z_o}, {15'h0, s9[7:0] == 0});
      end
    end

    // R2 R4 subtract sweep
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 3) begin
        idle(); alu_op = 3'd1; alu_a = a[7:0]; alu_b = b[7:0];
        upd_z = 1; upd_cdc = 1; tick();
        check("R4 sub C", {15'h0, c_o}, {15'h0, a >= b});
        check("R4 sub DC", {15'h0, dc_o}, {15'h0, (a % 16) >= (b % 16)});
        check("R2 sub Z", {15'h0, z_o}, {15'h0, a == b});
      end
    end

    // R2 R5 logic ops: Z tracks result, C/DC hold
    for (int op = 2; op < 5; op++) begin
      for (int a = 0; a < 256; a += 5) begin
        for (int b = 0; b < 256; b += 7) begin
          write_reg({5'b0, 3'b011 ^ {1'b0, a[0], b[0]}});
          idle(); alu_op = op[2:0]; alu_a = a[7:0]; alu_b = b[7:0];
          upd_z = 1; upd_cdc = 1; tick();
          exp8 = (op == 2) ? (a[7:0] & b[7:0]) : (op == 3) ? (a[7:0] | b[7:0])
                                                           : (a[7:0] ^ b[7:0]);
          check("R2 logic Z", {15'h0, z_o}, {15'h0, exp8 == 0});
          check("R5 logic keeps DC/C", {14'h0, dc_o, c_o},
                {14'h0, 2'b11 ^ {a[0], b[0]}});
        end
      end
    end

    // R5 no enables: nothing moves
    write_reg(8'h05);
    idle(); alu_op = 3'd0; alu_a = 8'hFF; alu_b = 8'h01; tick();
    check("R5 hold flags", {13'h0, z_o, dc_o, c_o}, 16'h0005);

    // R9 write and update together
    write_reg(8'h07);
    idle(); wr_en = 1; wr_data = 8'hA0; alu_op = 3'd1; alu_a = 8'h10; alu_b = 8'h10;
    upd_z = 1; upd_cdc = 1; tick(); idle();
    check("R9 update beats write", {8'h0, status_q}, 16'h00BF);
    idle(); wr_en = 1; wr_data = 8'h07; alu_op = 3'd0; alu_a = 8'h01; alu_b = 8'h01;
    upd_z = 1; tick(); idle();
    check("R9 Z from update, C/DC from write", {8'h0, status_q}, 16'h001B);

    // R10 R11 all event combos from every TO/PD start state
    for (int st = 0; st < 4; st++) begin
      for (int e = 0; e < 8; e++) begin
        case (st)
          0: events(0, 1, 0);
          1: events(1, 0, 1);
          2: events(1, 0, 0);
          default: events(0, 1, 1);
        endcase
        eto = (st == 0 || st == 2);
        epd = (st == 0 || st == 3);
        check("R10 R11 start state", {14'h0, status_q[4:3]}, {14'h0, eto, epd});
        events(e[2], e[1], e[0]);
        if (e[0]) eto = 0; else if (e[2] | e[1]) eto = 1;
        if (e[2]) epd = 0; else if (e[1]) epd = 1;
        check("R10 TO", {15'h0, status_q[4]}, {15'h0, eto});
        check("R11 PD", {15'h0, status_q[3]}, {15'h0, epd});
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule